// File: doc/BRIEF.md
# Variable-Page Paired TLB Lookup

This block is a fully associative translation lookaside buffer for a 32-bit MMU. Each entry covers two neighbouring virtual pages, one even and one odd, and carries a page-size mask of its own. One page frame base, one valid bit and one dirty bit are kept for each half. An entry applies to every address space when its global bit is set. Otherwise it applies only to the address space whose 8-bit identifier it stores.

A lookup is purely combinational. The caller presents a virtual address, the current address-space identifier and a read/write flag. In the same cycle the block reports one of four outcomes: a hit with the physical address and a writable flag, a miss, an invalid-half fault or a modified (write-protect) fault. It also reports the index of the entry that was used. Entries live in registers and are loaded one at a time through a write port. Each loaded entry applies to lookups from the next cycle on.

Top module: `tlbv_lookup`

## Requirements
- R1: After reset every entry holds all-zero fields: VPN 0, mask 0, ASID 0, not global, both halves not valid and not dirty. A lookup with a nonzero ASID then misses. A lookup of address 0 with ASID 0 returns invalid on entry 0.
- R2: When `wr_en` is high at a rising clock edge, all fields of entry `wr_idx` are replaced. Lookups in the following cycles see the new contents.
- R3: The effective mask of an entry is its stored mask ORed with 0x1FFF. An entry's address compare ignores every bit under the effective mask, both in the lookup address and in the stored VPN.
- R4: An entry matches only when the masked address equals the masked VPN and either its global bit is set or its stored ASID equals `lk_asid`.
- R5: The half is selected by the address bit at the highest set bit of the effective mask. A 0 there selects the even half (`wr_*[0]`, `wr_pfn_even`) and a 1 selects the odd half (`wr_*[1]`, `wr_pfn_odd`).
- R6: If the valid bit of the selected half is clear, `lk_status` is 2 (invalid).
- R7: A write lookup of a valid half whose dirty bit is clear gives `lk_status` 3 (modified). A read of that half is a hit with `lk_writable` 0. A hit on a dirty half gives `lk_writable` 1.
- R8: On a hit (`lk_status` 0), `lk_pa` is the selected half's frame base ORed with the address bits under the effective mask shifted right by one. Otherwise `lk_pa` and `lk_writable` are 0.
- R9: When several entries match, the lowest-numbered one decides the result, and `lk_idx` reports its number.
- R10: When no entry matches, `lk_status` is 1 (miss) and `lk_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry at this edge |
| wr_idx | input | IDX_W | Entry to load |
| wr_vpn | input | VA_W | Virtual page-pair base |
| wr_pmask | input | VA_W | Page-size mask (bits above the fixed minimum) |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches every address space |
| wr_pfn_even | input | PA_W | Frame base of the even half |
| wr_pfn_odd | input | PA_W | Frame base of the odd half |
| wr_valid | input | 2 | Valid bits, [0] even, [1] odd |
| wr_dirty | input | 2 | Dirty bits, [0] even, [1] odd |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_status | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| lk_pa | output | PA_W | Physical address on a hit |
| lk_writable | output | 1 | Write allowed on a hit |
| lk_idx | output | IDX_W | Number of the deciding entry |

## Verification
The bench builds the block with its defaults: 16 entries, 32-bit addresses and 8-bit ASIDs. With these values it can load a 64 KB pair at entry 3 and a 4 KB pair at entry 5 that cover the same addresses. This reaches the priority rule, and after the global bit of entry 3 is dropped by a reload, the ASID filter and the fallback to entry 5. The zeroed reset contents at index 0 give the invalid path without any load. The 64 KB entry moves the half-select bit from bit 12 up to bit 16, and it widens the offset that is passed through to the physical address.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

   typedef enum logic [1:0] {
      ST_HIT      = 2'd0,
      ST_MISS     = 2'd1,
      ST_INVALID  = 2'd2,
      ST_MODIFIED = 2'd3
   } tlbv_status_e;

endpackage

// File: rtl/tlbv_store.sv
module tlbv_store #(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 8,
   parameter int IDX_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_pmask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  logic [1:0]        wr_valid,
   input  logic [1:0]        wr_dirty,
   output logic [VA_W-1:0]   vpn_q   [ENTRIES],
   output logic [VA_W-1:0]   pmask_q [ENTRIES],
   output logic [ASID_W-1:0] asid_q  [ENTRIES],
   output logic              glb_q   [ENTRIES],
   output logic [PA_W-1:0]   pfn0_q  [ENTRIES],
   output logic [PA_W-1:0]   pfn1_q  [ENTRIES],
   output logic [1:0]        valid_q [ENTRIES],
   output logic [1:0]        dirty_q [ENTRIES]
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel_this;
      assign sel_this = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_q[e]   <= '0;
            pmask_q[e] <= '0;
            asid_q[e]  <= '0;
            glb_q[e]   <= 1'b0;
            pfn0_q[e]  <= '0;
            pfn1_q[e]  <= '0;
            valid_q[e] <= '0;
            dirty_q[e] <= '0;
         end else if (sel_this) begin
            vpn_q[e]   <= wr_vpn;
            pmask_q[e] <= wr_pmask;
            asid_q[e]  <= wr_asid;
            glb_q[e]   <= wr_global;
            pfn0_q[e]  <= wr_pfn_even;
            pfn1_q[e]  <= wr_pfn_odd;
            valid_q[e] <= wr_valid;
            dirty_q[e] <= wr_dirty;
         end
      end
   end

endmodule

// File: rtl/tlbv_match.sv
module tlbv_match #(
   parameter int VA_W          = 32,
   parameter int ASID_W        = 8,
   parameter int MIN_PAGE_BITS = 12
) (
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [VA_W-1:0]   ent_vpn,
   input  logic [VA_W-1:0]   ent_pmask,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic              ent_glb,
   output logic              hit,
   output logic              odd,
   output logic [VA_W-1:0]   half_mask
);

   localparam logic [VA_W-1:0] ONE      = {{(VA_W-1){1'b0}}, 1'b1};
   localparam logic [VA_W-1:0] MIN_MASK = (ONE << (MIN_PAGE_BITS + 1)) - ONE;

   logic [VA_W-1:0] eff_mask;
   logic [VA_W-1:0] top_bit;
   logic            space_ok;
   logic            tag_ok;

   always_comb begin
      eff_mask  = ent_pmask | MIN_MASK;
      half_mask = eff_mask >> 1;
      top_bit   = eff_mask & ~half_mask;
      space_ok  = ent_glb || (ent_asid == cur_asid);
      tag_ok    = (va & ~eff_mask) == (ent_vpn & ~eff_mask);
      hit       = space_ok && tag_ok;
      odd       = |(va & top_bit);
   end

endmodule

// File: rtl/tlbv_prio.sv
module tlbv_prio #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     win_oh,
   output logic [IDX_W-1:0] win_idx,
   output logic             win_any
);

   always_comb begin
      win_any = |req;
      win_oh  = req & ~(req - N'(1));
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) win_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlbv_lookup.sv
module tlbv_lookup #(
   parameter int ENTRIES       = 16,
   parameter int VA_W          = 32,
   parameter int PA_W          = 32,
   parameter int ASID_W        = 8,
   parameter int MIN_PAGE_BITS = 12,
   localparam int IDX_W        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_pmask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  logic [1:0]        wr_valid,
   input  logic [1:0]        wr_dirty,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic [1:0]        lk_status,
   output logic [PA_W-1:0]   lk_pa,
   output logic              lk_writable,
   output logic [IDX_W-1:0]  lk_idx
);
   import tlbv_pkg::*;

   if (ENTRIES < 1) begin : g_bad_entries
      $error("tlbv_lookup: ENTRIES must be at least 1");
   end
   if (VA_W < MIN_PAGE_BITS + 2) begin : g_bad_va
      $error("tlbv_lookup: VA_W too small for the minimum page pair");
   end
   if (PA_W < VA_W) begin : g_bad_pa
      $error("tlbv_lookup: PA_W must not be narrower than VA_W");
   end

   logic [VA_W-1:0]   vpn_q   [ENTRIES];
   logic [VA_W-1:0]   pmask_q [ENTRIES];
   logic [ASID_W-1:0] asid_q  [ENTRIES];
   logic              glb_q   [ENTRIES];
   logic [PA_W-1:0]   pfn0_q  [ENTRIES];
   logic [PA_W-1:0]   pfn1_q  [ENTRIES];
   logic [1:0]        valid_q [ENTRIES];
   logic [1:0]        dirty_q [ENTRIES];

   tlbv_store #(
      .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
      .ASID_W(ASID_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
      .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_valid(wr_valid), .wr_dirty(wr_dirty),
      .vpn_q(vpn_q), .pmask_q(pmask_q), .asid_q(asid_q), .glb_q(glb_q),
      .pfn0_q(pfn0_q), .pfn1_q(pfn1_q), .valid_q(valid_q), .dirty_q(dirty_q)
   );

   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] odd_vec;
   logic [VA_W-1:0]    half_arr [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      tlbv_match #(
         .VA_W(VA_W), .ASID_W(ASID_W), .MIN_PAGE_BITS(MIN_PAGE_BITS)
      ) u_match (
         .va(lk_va), .cur_asid(lk_asid),
         .ent_vpn(vpn_q[e]), .ent_pmask(pmask_q[e]),
         .ent_asid(asid_q[e]), .ent_glb(glb_q[e]),
         .hit(hit_vec[e]), .odd(odd_vec[e]), .half_mask(half_arr[e])
      );
   end

   logic [ENTRIES-1:0] win_oh;
   logic [IDX_W-1:0]   win_idx;
   logic               win_any;

   tlbv_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
      .req(hit_vec), .win_oh(win_oh), .win_idx(win_idx), .win_any(win_any)
   );

   logic            sel_odd;
   logic            sel_valid;
   logic            sel_dirty;
   logic [PA_W-1:0] sel_pfn;
   logic [VA_W-1:0] sel_half;
   tlbv_status_e    status;

   always_comb begin
      sel_odd   = odd_vec[win_idx];
      sel_half  = half_arr[win_idx];
      sel_valid = sel_odd ? valid_q[win_idx][1] : valid_q[win_idx][0];
      sel_dirty = sel_odd ? dirty_q[win_idx][1] : dirty_q[win_idx][0];
      sel_pfn   = sel_odd ? pfn1_q[win_idx]     : pfn0_q[win_idx];

      if (!win_any)                   status = ST_MISS;
      else if (!sel_valid)            status = ST_INVALID;
      else if (lk_write && !sel_dirty) status = ST_MODIFIED;
      else                            status = ST_HIT;

      lk_status   = status;
      lk_idx      = win_idx;
      lk_writable = (status == ST_HIT) && sel_dirty;
      lk_pa       = (status == ST_HIT) ? (sel_pfn | PA_W'(lk_va & sel_half)) : '0;
   end

endmodule

// File: rtl/tlbv_lookup_chk.sv
module tlbv_lookup_chk #(
   parameter int ENTRIES       = 16,
   parameter int VA_W          = 32,
   parameter int PA_W          = 32,
   parameter int MIN_PAGE_BITS = 12,
   parameter int IDX_W         = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [VA_W-1:0]    lk_va,
   input logic               lk_write,
   input logic [1:0]         lk_status,
   input logic [PA_W-1:0]    lk_pa,
   input logic               lk_writable,
   input logic [IDX_W-1:0]   lk_idx,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [ENTRIES-1:0] win_oh
);
   import tlbv_pkg::*;

   localparam logic [PA_W-1:0] ONE_PA   = {{(PA_W-1){1'b0}}, 1'b1};
   localparam logic [PA_W-1:0] OFF_MASK = (ONE_PA << MIN_PAGE_BITS) - ONE_PA;

   logic [PA_W-1:0] va_wide;
   assign va_wide = PA_W'(lk_va);

   // R8: the minimum page offset always reaches the physical address
   p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_status == ST_HIT) |-> ((lk_pa & va_wide & OFF_MASK) == (va_wide & OFF_MASK)));

   // R7: a successful write always reports a writable page
   p_write_hit_writable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_status == ST_HIT && lk_write) |-> lk_writable);

   // R7: a modified fault arises only from a write
   p_modified_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_status == ST_MODIFIED) |-> lk_write);

   // R9: at most one entry is chosen
   p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_oh));

   // R9: the reported index is a matching entry with no lower match
   p_lowest_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |-> (hit_vec[lk_idx] &&
                      ((hit_vec & ((ENTRIES'(1) << lk_idx) - ENTRIES'(1))) == '0)));

   // R10: a miss only when no comparator fires
   p_miss_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_status == ST_MISS) |-> (hit_vec == '0));

   // R8: no address or permission leaks outside a hit
   p_quiet_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_status != ST_HIT) |-> (lk_pa == '0 && !lk_writable));

endmodule

bind tlbv_lookup tlbv_lookup_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
   .MIN_PAGE_BITS(MIN_PAGE_BITS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_write(lk_write),
   .lk_status(lk_status), .lk_pa(lk_pa), .lk_writable(lk_writable),
   .lk_idx(lk_idx), .hit_vec(hit_vec), .win_oh(win_oh)
);

// File: tb/tlbv_lookup_test.sv
module tlbv_lookup_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_vpn = '0;
   logic [31:0] wr_pmask = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [31:0] wr_pfn_even = '0;
   logic [31:0] wr_pfn_odd = '0;
   logic [1:0]  wr_valid = '0;
   logic [1:0]  wr_dirty = '0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic [1:0]  lk_status;
   logic [31:0] lk_pa;
   logic        lk_writable;
   logic [3:0]  lk_idx;

   tlbv_lookup uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
      .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_valid(wr_valid), .wr_dirty(wr_dirty),
      .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
      .lk_status(lk_status), .lk_pa(lk_pa), .lk_writable(lk_writable),
      .lk_idx(lk_idx)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      string       tag;
      logic [1:0]  status;
      logic [31:0] pa;
      logic        writable;
      logic [3:0]  idx;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;

   task automatic check_val(string tag, string what, logic [31:0] got, logic [31:0] want);
      n_checks++;
      if (got !== want) begin
         n_errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
      end
   endtask

   // monitor: compares the oldest expected item against the outputs
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         check_val(it.tag, "status",   32'(lk_status),   32'(it.status));
         check_val(it.tag, "pa",       lk_pa,            it.pa);
         check_val(it.tag, "writable", 32'(lk_writable), 32'(it.writable));
         check_val(it.tag, "idx",      32'(lk_idx),      32'(it.idx));
      end
   end

   task automatic load(input logic [3:0] idx, input logic [31:0] vpn,
                       input logic [31:0] pmask, input logic [7:0] asid,
                       input logic glb, input logic [31:0] p0, input logic [31:0] p1,
                       input logic [1:0] v, input logic [1:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pmask = pmask;
      wr_asid = asid; wr_global = glb; wr_pfn_even = p0; wr_pfn_odd = p1;
      wr_valid = v; wr_dirty = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // driver: applies a lookup and queues what the requirements predict
   task automatic lookup(input string tag, input logic [31:0] va,
                         input logic [7:0] asid, input logic wr,
                         input logic [1:0] st, input logic [31:0] pa,
                         input logic wbl, input logic [3:0] idx);
      exp_t it;
      @(posedge clk); #1;
      lk_va = va; lk_asid = asid; lk_write = wr;
      it.tag = tag; it.status = st; it.pa = pa; it.writable = wbl; it.idx = idx;
      exp_q.push_back(it);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: zeroed entries; non-zero ASID misses, ASID 0 hits invalid entry 0
      lookup("R1 reset other asid", 32'h0000_0000, 8'h05, 1'b0, 2'd1, 32'h0, 1'b0, 4'd0);
      lookup("R1 R6 reset asid0", 32'h0000_0000, 8'h00, 1'b0, 2'd2, 32'h0, 1'b0, 4'd0);

      // 4 KB pair at entry 0, odd half clean
      load(4'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0,
           32'h1000_0000, 32'h2000_0000, 2'b11, 2'b01);
      lookup("R2 R5 R8 even read", 32'h0040_0123, 8'h11, 1'b0, 2'd0, 32'h1000_0123, 1'b1, 4'd0);
      lookup("R7 odd write clean", 32'h0040_1456, 8'h11, 1'b1, 2'd3, 32'h0, 1'b0, 4'd0);
      lookup("R7 R5 odd read clean", 32'h0040_1456, 8'h11, 1'b0, 2'd0, 32'h2000_0456, 1'b0, 4'd0);
      lookup("R4 R10 asid mismatch", 32'h0040_0123, 8'h12, 1'b0, 2'd1, 32'h0, 1'b0, 4'd0);

      // 64 KB global pair at entry 3, odd half invalid
      load(4'd3, 32'h0080_0000, 32'h0001_E000, 8'h55, 1'b1,
           32'h0300_0000, 32'h0400_0000, 2'b01, 2'b01);
      lookup("R3 R4 global big write", 32'h0080_ABCD, 8'h99, 1'b1, 2'd0, 32'h0300_ABCD, 1'b1, 4'd3);
      lookup("R6 R5 big odd invalid", 32'h0081_2345, 8'h99, 1'b0, 2'd2, 32'h0, 1'b0, 4'd3);
      lookup("R3 R10 just beyond pair", 32'h0082_0000, 8'h99, 1'b0, 2'd1, 32'h0, 1'b0, 4'd0);

      // 4 KB pair at entry 5 overlapping, VPN low bits set (ignored)
      load(4'd5, 32'h0080_1ABC, 32'h0, 8'h99, 1'b0,
           32'h0500_0000, 32'h0600_0000, 2'b11, 2'b11);
      lookup("R9 lower index wins", 32'h0080_0010, 8'h99, 1'b0, 2'd0, 32'h0300_0010, 1'b1, 4'd3);

      // reload entry 3 as non-global for ASID 0x55
      load(4'd3, 32'h0080_0000, 32'h0001_E000, 8'h55, 1'b0,
           32'h0300_0000, 32'h0400_0000, 2'b01, 2'b01);
      lookup("R2 R9 R3 fallback entry5", 32'h0080_0010, 8'h99, 1'b0, 2'd0, 32'h0500_0010, 1'b1, 4'd5);
      lookup("R7 R5 entry5 odd dirty write", 32'h0080_1010, 8'h99, 1'b1, 2'd0, 32'h0600_0010, 1'b1, 4'd5);
      lookup("R4 R6 own asid invalid", 32'h0081_0000, 8'h55, 1'b0, 2'd2, 32'h0, 1'b0, 4'd3);

      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule